// File: doc/BRIEF.md
# I2C Register-Pair Slave Interface

This block is the serial front end of a 16-bit port expander. It watches an I2C or SMBus segment whose clock and data lines have already been brought into the system clock domain. It recognises bus START and STOP events and answers to one seven-bit address. The upper four bits of that address are a fixed pattern, and the lower three are taken from strap pins. The block then turns bus transfers into single-cycle strobes towards a byte-wide register file of eight locations.

A write transfer first carries a command byte, and its low three bits set a stored register pointer. Each further data byte is written to the register the pointer selects. A read transfer streams bytes out from the pointer. The pointer does not count upward through the address space. After every data byte, whether written or read, only its lowest bit flips, so a burst alternates between the two registers of a pair. The pointer keeps its value across transfers. A read is normally a command write, then a repeated START with the read bit set. Registers 0 and 1 are read-only input ports.

The block only ever pulls the data line low, through an enable output. It does not stretch the clock. The system clock must run at least eight times faster than the bus clock.

Top module: `i2c_pair_slave`

## Requirements
- R1: After reset the data-line enable is off, no register strobe is issued, and the pointer is 0, so a read with no command byte returns register 0.
- R2: The slave acknowledges only the address byte whose top seven bits are 0100 followed by the three strap bits. Bit 0 of that byte selects read (1) or write (0). After a mismatch it never drives the data line, and it issues no strobe until the next START.
- R3: A START is the data line falling while the clock is high, and a STOP is the data line rising while the clock is high. Before the first START, all bus activity is ignored.
- R4: The first byte after a write address is a command byte. Its bits 2:0 load the pointer and bits 7:3 are ignored.
- R5: Every data byte received in write mode is acknowledged. If the pointer is 2 to 7, the byte raises the write strobe for one cycle with the register address equal to the pointer and the write data equal to the byte.
- R6: After each data byte written or read, pointer bit 0 inverts and the other bits hold. For example, 7 is followed by 6, and 2 is followed by 3.
- R7: Data bytes written while the pointer is 0 or 1 are acknowledged but raise no write strobe.
- R8: In read mode each byte is taken from the register file at the start of the byte. At that moment the read strobe is raised with the register address equal to the pointer. The byte is then shifted out MSB first.
- R9: After a read byte, a master acknowledge (data low on the ninth clock) starts the next byte. A master non-acknowledge stops transmission, and the slave leaves the line released until the next START.
- R10: The pointer is kept across STOP and repeated START.
- R11: A STOP or START in the middle of a byte abandons it with no strobe. A START always returns the slave to address reception.
- R12: The slave changes its data-line enable only while the clock is low. A STOP leaves the line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| strap_i | input | 3 | Hardwired low address bits |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| reg_addr_o | output | 3 | Register address for the strobes |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rd_o | output | 1 | One-cycle read strobe; read data sampled in this cycle |
| reg_rdata_i | input | 8 | Register file read data for reg_addr_o |

## Verification
A pointer that flips the wrong bit, or is not kept between transfers, shows up at once. Either the second strobe of a burst carries the wrong address, or the first byte of the next read comes from the wrong register. A wrong bit count or a wrong shift state moves the acknowledge by one clock. The master then sees the acknowledge missing at the ninth clock of the same byte, or read data shifted by one bit. A receiver that does not return to address reception on STOP or START either acknowledges an address it should ignore, or fires a strobe for a partial byte, within one transfer.

// File: rtl/i2c_pair_pkg.sv
// Shared types for the register-pair I2C slave.
package i2c_pair_pkg;
    // Link states of the slave byte engine
    typedef enum logic [3:0] {
        ST_IDLE,   // released, waiting for START
        ST_ADDR,   // shifting in address byte
        ST_AACK,   // driving address acknowledge
        ST_CMD,    // shifting in command byte
        ST_CACK,   // driving command acknowledge
        ST_WDAT,   // shifting in write data byte
        ST_WACK,   // driving data acknowledge
        ST_RDAT,   // shifting out read data byte
        ST_RACK    // sampling master acknowledge
    } link_state_t;
endpackage

// File: rtl/i2c_line_events.sv
// Bus event detector: compares the current synchronised SCL/SDA levels with
// the previous system-clock sample and flags clock edges, START and STOP.
// Assumes inputs are already synchronised and the clock oversamples SCL.
module i2c_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    // Hold previous line levels (idle bus reads high)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode edges and bus conditions from old and new samples
    always_comb begin
        scl_rise_o = scl_i && !scl_q;
        scl_fall_o = !scl_i && scl_q;
        start_o    = scl_i && scl_q && sda_q && !sda_i;
        stop_o     = scl_i && scl_q && !sda_q && sda_i;
    end
endmodule

// File: rtl/i2c_pair_pointer.sv
// Register pointer: loaded from a command byte, then toggles only its least
// significant bit on each step so bursts alternate within a register pair.
// Assumes load and step are never asserted in the same cycle.
module i2c_pair_pointer #(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [PTR_W-1:0] load_val_i,
    input  logic             step_i,
    output logic [PTR_W-1:0] ptr_o
);
    localparam logic [PTR_W-1:0] PAIR_FLIP = PTR_W'(1);

    // Pointer register: reset to 0, load or flip pair member
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_o <= '0;
        else if (load_i)
            ptr_o <= load_val_i;
        else if (step_i)
            ptr_o <= ptr_o ^ PAIR_FLIP;
    end
endmodule

// File: rtl/i2c_pair_slave.sv
// I2C slave front end for a register-pair port expander. Matches a fixed
// upper address nibble plus strap bits, takes a command byte as register
// pointer, and converts write/read bursts into register strobes. The pointer
// alternates within a pair after every data byte. No clock stretching.
// Assumes synchronised SCL/SDA and clk >= 8x SCL; reg_rdata_i is a
// combinational function of reg_addr_o.
module i2c_pair_slave #(
    parameter logic [3:0] FIXED_HI = 4'b0100,
    parameter int         STRAP_W  = 3,
    parameter int         DATA_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe_o,
    output logic [STRAP_W-1:0] reg_addr_o,
    output logic               reg_wr_o,
    output logic [DATA_W-1:0]  reg_wdata_o,
    output logic               reg_rd_o,
    input  logic [DATA_W-1:0]  reg_rdata_i
);
    import i2c_pair_pkg::*;

    localparam int PTR_W = STRAP_W;
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(DATA_W - 1);

    logic                scl_rise, scl_fall, bus_start, bus_stop;
    link_state_t         state;
    logic [CNT_W-1:0]    bit_cnt;
    logic [DATA_W-1:0]   shreg;
    logic                rw_bit;
    logic                m_ack;
    logic [PTR_W-1:0]    ptr;
    logic                addr_hit, rd_load, wr_done, ptr_load, ptr_step;

    i2c_line_events ev_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(bus_start), .stop_o(bus_stop)
    );

    i2c_pair_pointer #(.PTR_W(PTR_W)) ptr_i (
        .clk(clk), .rst_n(rst_n), .load_i(ptr_load),
        .load_val_i(shreg[PTR_W-1:0]), .step_i(ptr_step), .ptr_o(ptr)
    );

    // Decode address match, strobes and pointer control for this cycle
    always_comb begin
        addr_hit = (shreg[DATA_W-1:1] == {FIXED_HI, strap_i});
        rd_load  = scl_fall && (((state == ST_AACK) && rw_bit) ||
                                ((state == ST_RACK) && m_ack));
        wr_done  = scl_fall && (state == ST_WDAT) && (bit_cnt == LAST_RX);
        ptr_load = scl_fall && (state == ST_CMD) && (bit_cnt == LAST_RX);
        ptr_step = wr_done ||
                   (scl_fall && (state == ST_RDAT) && (bit_cnt == LAST_TX));
        reg_addr_o  = ptr;
        reg_wdata_o = shreg;
        reg_rd_o    = rd_load;
        reg_wr_o    = wr_done && (ptr[PTR_W-1:1] != '0);
    end

    // Byte engine: bus conditions, bit shifting, acknowledge and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            rw_bit   <= 1'b0;
            m_ack    <= 1'b0;
            sda_oe_o <= 1'b0;
        end else if (bus_start) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            sda_oe_o <= 1'b0;
        end else if (bus_stop) begin
            state    <= ST_IDLE;
            sda_oe_o <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_CMD, ST_WDAT: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[DATA_W-2:0], sda_i};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && (bit_cnt == LAST_RX)) begin
                        if (state == ST_ADDR) begin
                            if (addr_hit) begin
                                state    <= ST_AACK;
                                rw_bit   <= shreg[0];
                                sda_oe_o <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            state    <= (state == ST_CMD) ? ST_CACK : ST_WACK;
                            sda_oe_o <= 1'b1;
                        end
                    end
                end
                ST_AACK, ST_RACK: begin
                    if (state == ST_RACK && scl_rise)
                        m_ack <= !sda_i;
                    if (scl_fall) begin
                        if (rd_load) begin
                            state    <= ST_RDAT;
                            shreg    <= reg_rdata_i;
                            sda_oe_o <= !reg_rdata_i[DATA_W-1];
                            bit_cnt  <= '0;
                        end else begin
                            state    <= (state == ST_AACK) ? ST_CMD : ST_IDLE;
                            sda_oe_o <= 1'b0;
                            bit_cnt  <= '0;
                        end
                    end
                end
                ST_CACK, ST_WACK: begin
                    if (scl_fall) begin
                        state    <= ST_WDAT;
                        sda_oe_o <= 1'b0;
                        bit_cnt  <= '0;
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        if (bit_cnt == LAST_TX) begin
                            state    <= ST_RACK;
                            sda_oe_o <= 1'b0;
                        end else begin
                            shreg    <= {shreg[DATA_W-2:0], 1'b0};
                            sda_oe_o <= !shreg[DATA_W-2];
                            bit_cnt  <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: sda_oe_o <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/i2c_pair_slave_chk.sv
// Protocol checker for i2c_pair_slave, attached through bind. Observes only
// the top-level ports and keeps its own view of the bus lines.
module i2c_pair_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_i,
    input logic       sda_oe_o,
    input logic       reg_wr_o,
    input logic       reg_rd_o,
    input logic [7:0] reg_rdata_i
);
    // R12
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    // R12
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_oe_o);

    // R5
    wr_ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> sda_oe_o);

    // R8
    rd_msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |=> (sda_oe_o == !$past(reg_rdata_i[7])));

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_o, reg_rd_o}));
endmodule

bind i2c_pair_slave i2c_pair_slave_chk chk_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_oe_o(sda_oe_o), .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o),
    .reg_rdata_i(reg_rdata_i)
);

// File: tb/i2c_pair_slave_tb_top.sv
// Self-checking bench: bit-level I2C master, behavioural register file,
// table of write bursts, then directed reset and corner-case tests.
module i2c_pair_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] AW = 8'h4A;   // 0100_101_0
    localparam logic [7:0] AR = 8'h4B;   // 0100_101_1
    localparam int NVEC = 4;
    // {command, first data, second data}
    localparam logic [23:0] WR_VEC [NVEC] = '{
        {8'hF7, 8'h11, 8'h22}, {8'h02, 8'hA5, 8'h3C},
        {8'h05, 8'h0F, 8'hF0}, {8'h06, 8'h81, 8'h7E}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, reg_wr, reg_rd, bus_sda;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] regs [8];
    int   wr_cnt = 0, rd_cnt = 0;
    logic [2:0] wr_addr_log [64];
    logic [7:0] wr_data_log [64];
    logic [2:0] last_rd_addr;
    int   checks = 0, errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign bus_sda = m_sda & ~sda_oe;
    assign reg_rdata = regs[reg_addr];

    i2c_pair_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
        .strap_i(3'b101), .sda_oe_o(sda_oe), .reg_addr_o(reg_addr),
        .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata), .reg_rd_o(reg_rd),
        .reg_rdata_i(reg_rdata));

    // Register file model and strobe log
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) regs[i] <= 8'(i * 8'h11);
            regs[0] <= 8'h5A;
            regs[1] <= 8'hC3;
        end else begin
            if (reg_wr) begin
                regs[reg_addr] <= reg_wdata;
                wr_addr_log[wr_cnt[5:0]] <= reg_addr;
                wr_data_log[wr_cnt[5:0]] <= reg_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (reg_rd) begin
                last_rd_addr <= reg_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();  // also serves as repeated START
        m_sda = 1'b1; tick(2); m_scl = 1'b1; tick(4);
        m_sda = 1'b0; tick(4); m_scl = 1'b0; tick(4);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; tick(2); m_scl = 1'b1; tick(4); m_sda = 1'b1; tick(4);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; tick(2); m_scl = 1'b1; tick(4); m_scl = 1'b0; tick(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_sda = 1'b1; tick(2); m_scl = 1'b1; tick(2);
        ack = !bus_sda; tick(2); m_scl = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(2); m_scl = 1'b1; tick(2); b[i] = bus_sda; tick(2);
            m_scl = 1'b0;
        end
        tick(1); m_sda = !give_ack; tick(1); m_scl = 1'b1; tick(4);
        m_scl = 1'b0; tick(2); m_sda = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] d;
        int w0, r0;
        tick(4); rst_n = 1'b1; tick(4);
        // R1 reset state
        chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
        chk(wr_cnt == 0 && rd_cnt == 0, "R1 no strobes", wr_cnt + rd_cnt, 0);

        // R3 bytes clocked without START are ignored
        m_scl = 1'b0; tick(4);
        send_byte(AW, a);
        chk(!a, "R3 no ack before START", a, 0);
        m_scl = 1'b1; tick(4);

        // R1 pointer resets to 0: plain read returns register 0
        m_start(); send_byte(AR, a);
        chk(a, "R2 read address ack", a, 1);
        recv_byte(1'b0, d);
        chk(d == 8'h5A, "R1 read reg0 data", d, 8'h5A);
        chk(last_rd_addr == 3'd0, "R1 read reg0 addr", last_rd_addr, 0);
        m_stop();

        // R4 R5 R6 table of write bursts
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] c, d0, d1;
            logic [2:0] p;
            {c, d0, d1} = WR_VEC[v];
            p = c[2:0];
            w0 = wr_cnt;
            m_start(); send_byte(AW, a);
            chk(a, "R2 write address ack", a, 1);
            send_byte(c, a);  chk(a, "R4 command ack", a, 1);
            send_byte(d0, a); chk(a, "R5 data0 ack", a, 1);
            send_byte(d1, a); chk(a, "R5 data1 ack", a, 1);
            m_stop();
            chk(wr_cnt == w0 + 2, "R5 write strobe count", wr_cnt - w0, 2);
            chk(wr_addr_log[w0] == p, "R4 first address", wr_addr_log[w0], p);
            chk(wr_data_log[w0] == d0, "R5 first data", wr_data_log[w0], d0);
            chk(wr_addr_log[w0+1] == (p ^ 3'd1), "R6 pair toggle",
                wr_addr_log[w0+1], p ^ 3'd1);
            chk(wr_data_log[w0+1] == d1, "R5 second data", wr_data_log[w0+1], d1);
        end

        // R7 writes to input ports acknowledged, no strobe
        w0 = wr_cnt;
        m_start(); send_byte(AW, a); send_byte(8'h00, a);
        send_byte(8'h99, a); chk(a, "R7 input write ack", a, 1);
        send_byte(8'h77, a); chk(a, "R7 input write ack 2", a, 1);
        m_stop();
        chk(wr_cnt == w0, "R7 no strobe", wr_cnt - w0, 0);

        // R8 R9 R10 command then repeated START read burst
        m_start(); send_byte(AW, a); send_byte(8'h03, a);
        m_start(); send_byte(AR, a);
        chk(a, "R10 repeated START ack", a, 1);
        recv_byte(1'b1, d); chk(d == 8'h3C, "R8 read byte reg3", d, 8'h3C);
        recv_byte(1'b1, d); chk(d == 8'hA5, "R6 read byte reg2", d, 8'hA5);
        recv_byte(1'b0, d); chk(d == 8'h3C, "R9 read after ack", d, 8'h3C);
        chk(last_rd_addr == 3'd3, "R8 read strobe address", last_rd_addr, 3);
        r0 = rd_cnt;
        recv_byte(1'b0, d);
        chk(d == 8'hFF, "R9 released after NACK", d, 8'hFF);
        chk(rd_cnt == r0, "R9 no read after NACK", rd_cnt - r0, 0);
        m_stop();

        // R10 pointer persists across STOP (3 -> 2 -> 3 -> 2)
        m_start(); send_byte(AR, a); recv_byte(1'b0, d); m_stop();
        chk(d == 8'hA5, "R10 pointer kept", d, 8'hA5);

        // R2 address mismatch: strap bits and fixed bits
        w0 = wr_cnt;
        m_start(); send_byte(8'h48, a);
        chk(!a, "R2 strap mismatch nack", a, 0);
        send_byte(8'h02, a); chk(!a, "R2 silent after mismatch", a, 0);
        send_byte(8'h55, a); chk(!a, "R2 silent data", a, 0);
        m_stop();
        m_start(); send_byte(8'h6A, a);
        chk(!a, "R2 fixed bits mismatch nack", a, 0);
        m_stop();
        chk(wr_cnt == w0, "R2 no strobe on mismatch", wr_cnt - w0, 0);

        // R11 STOP and START inside a byte abandon it
        m_start(); send_byte(AW, a); send_byte(8'h04, a);
        send_bits(8'hFF, 4); m_stop();
        chk(wr_cnt == w0, "R11 partial byte then STOP", wr_cnt - w0, 0);
        m_start(); send_byte(AW, a); send_byte(8'h06, a);
        send_bits(8'h00, 3);
        m_start(); send_byte(AW, a);
        chk(a, "R11 address after mid-byte START", a, 1);
        chk(wr_cnt == w0, "R11 no strobe on mid-byte START", wr_cnt - w0, 0);
        send_byte(8'h05, a); send_byte(8'hE1, a); m_stop();
        chk(wr_cnt == w0 + 1, "R11 write after abort", wr_cnt - w0, 1);
        chk(wr_addr_log[w0] == 3'd5 && wr_data_log[w0] == 8'hE1,
            "R11 write target", {wr_addr_log[w0], wr_data_log[w0]}, {3'd5, 8'hE1});
        chk(sda_oe == 1'b0, "R12 released after STOP", sda_oe, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule